// File: doc/BRIEF.md
# Base Address Window Decoder

This block turns the contents of a device's configuration header into live address windows. It is given the command word, six base registers and an expansion-ROM register. Each window has a fixed power-of-two size and a fixed space type, either I/O or memory, set by parameters. The ROM window is always memory.

Every clock the block works out, for each window, whether it is mapped and at what aligned base. It holds that placement in registers. A window that its space bit disables, or whose placement is not valid, is held unmapped.

A transaction supplies an address and a space type. The block answers in the same cycle with every window that matches, a one-hot pick of the lowest-numbered match, and the byte offset into the picked window. Whenever a window's placement moves, a one-cycle pulse for that window tells an outside hook to unmap the old range and map the new one.

Top module: `bar_window_decoder`

## Requirements
- R1: I/O windows are mapped only while command bit 0 is 1. Memory windows and the ROM window are mapped only while command bit 1 is 1. A change on the command or register inputs shows on `win_mapped` one clock edge later.
- R2: The ROM window is mapped only while bit 0 of `rom_reg` is 1, in addition to command bit 1.
- R3: A window's base is its register value with the low log2(size) bits cleared. It claims the addresses from base to base+size-1 inclusive. For the picked window, `sel_offset` equals address minus base.
- R4: A window whose aligned base is zero is unmapped.
- R5: A window whose last address is not above its base is unmapped. With aligned bases, this is the case for a window of size 1.
- R6: An I/O window whose last address is 0x10000 or higher is unmapped.
- R7: A window of size zero is never mapped and never hit.
- R8: A transaction hits only windows of its own space type (`req_is_io`=1 for I/O, 0 for memory).
- R9: `hit_vec` shows all matching windows. `sel_vec` is one-hot on the lowest-numbered match, or zero with `sel_valid`=0 when nothing matches.
- R10: `place_chg[i]` pulses high for exactly one cycle, in the cycle that a new placement first shows. A new placement is window i turning mapped or unmapped, or a mapped window's base moving. Rewriting a register in a way that leaves the aligned base unchanged gives no pulse.
- R11: After reset, no window is mapped, nothing hits and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_reg | input | 16 | Command word; bit 0 enables I/O space, bit 1 enables memory space |
| bar_regs | input | NUM_BARS*32 | Base registers; register i in bits [32i+31:32i] |
| rom_reg | input | 32 | Expansion-ROM register; bit 0 is its own enable |
| req_addr | input | 32 | Transaction address |
| req_is_io | input | 1 | Transaction space: 1 = I/O, 0 = memory |
| hit_vec | output | NUM_BARS+1 | All windows matching the transaction; bit NUM_BARS is the ROM |
| sel_vec | output | NUM_BARS+1 | One-hot lowest-numbered match |
| sel_valid | output | 1 | At least one window matches |
| sel_offset | output | 32 | Address minus base of the picked window |
| win_mapped | output | NUM_BARS+1 | Registered mapped state of each window |
| place_chg | output | NUM_BARS+1 | One-cycle pulse when a window's placement changes |

## Verification
The command word is stepped through all four combinations of its two enable bits, which separates I/O gating from memory gating. The ROM enable bit is toggled with memory space on to show that it is a separate gate. Addresses at the first and last byte of a window, and one byte past it, test the inclusive range and the offset arithmetic. Transactions of the wrong space type show that the type is compared. Windows are placed on a zero base, on a size-1 slot and across the 64K I/O limit, and a size-zero slot is left in, so that each rule that unmaps a window is shown to act on its own. Overlapping memory windows tell the priority pick apart from the full hit vector. Pulses are watched both when a window moves and when a register rewrite leaves its base unchanged.

// File: rtl/bar_window_pkg.sv
package bar_window_pkg;
  localparam int AW = 32;
  localparam logic [AW-1:0] ONE = 1;
  localparam logic [AW-1:0] IO_LIMIT = 32'h0001_0000;

  // Aligned base: register value with the in-window bits cleared.
  function automatic logic [AW-1:0] win_align(input logic [AW-1:0] raw,
                                              input logic [AW-1:0] sz);
    return raw & ~(sz - ONE);
  endfunction

  // Placement validity for an aligned base.
  function automatic logic win_valid(input logic [AW-1:0] base,
                                     input logic [AW-1:0] sz,
                                     input logic is_io);
    logic [AW-1:0] last;
    last = base + sz - ONE;
    if (sz == '0) return 1'b0;
    if (base == '0) return 1'b0;
    if (last <= base) return 1'b0;
    if (is_io && (last >= IO_LIMIT)) return 1'b0;
    return 1'b1;
  endfunction
endpackage

// File: rtl/bar_window_eval.sv
module bar_window_eval
  import bar_window_pkg::*;
#(
  parameter logic [AW-1:0] SIZE = 32'h1000,
  parameter bit IS_IO = 1'b0,
  parameter bit IS_ROM = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] raw,
  input  logic          space_en,
  output logic          mapped_q,
  output logic [AW-1:0] base_q,
  output logic          chg_q
);
  logic          win_en;
  logic [AW-1:0] nxt_base;
  logic          nxt_mapped;
  logic          placement_moved;

  assign win_en = space_en && (!IS_ROM || raw[0]);
  assign nxt_base = win_align(raw, SIZE);
  assign nxt_mapped = win_en && win_valid(nxt_base, SIZE, IS_IO);
  assign placement_moved = (nxt_mapped != mapped_q) ||
                           (nxt_mapped && (nxt_base != base_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mapped_q <= 1'b0;
      base_q   <= '0;
      chg_q    <= 1'b0;
    end else begin
      mapped_q <= nxt_mapped;
      base_q   <= nxt_base;
      chg_q    <= placement_moved;
    end
  end

  assert_disabled_unmapped_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !space_en |=> !mapped_q);

  assert_nonzero_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mapped_q |-> (base_q != '0));

  assert_chg_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> (($past(mapped_q) != mapped_q) || ($past(base_q) != base_q)));

  assert_move_pulses_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mapped_q && $past(mapped_q) && ($past(base_q) != base_q)) |-> chg_q);

  generate
    if (IS_ROM) begin : g_rom
      assert_rom_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !raw[0] |=> !mapped_q);
    end
    if (IS_IO) begin : g_io
      assert_io_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mapped_q |-> ((base_q + (SIZE - ONE)) < IO_LIMIT));
    end
    if (SIZE == '0) begin : g_zero
      assert_zero_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped_q);
    end
    if (SIZE == ONE) begin : g_one
      assert_size_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped_q);
    end
  endgenerate
endmodule

// File: rtl/bar_hit_select.sv
module bar_hit_select
  import bar_window_pkg::*;
#(
  parameter int NREG = 7,
  parameter logic [NREG*AW-1:0] WIN_SIZE = '0,
  parameter logic [NREG-1:0] WIN_IO = '0,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREG-1:0]    mapped,
  input  logic [NREG*AW-1:0] bases,
  input  logic [AW-1:0]      addr,
  input  logic               is_io,
  output logic [NREG-1:0]    hit_vec,
  output logic [NREG-1:0]    sel_vec,
  output logic               sel_valid,
  output logic [AW-1:0]      offset
);
  logic [IDX_W-1:0] sel_idx;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_hit
      localparam logic [AW-1:0] SZ = WIN_SIZE[i*AW +: AW];
      assign hit_vec[i] = mapped[i] && (is_io == WIN_IO[i]) &&
                          (win_align(addr, SZ) == bases[i*AW +: AW]);
    end
  endgenerate

  always_comb begin
    sel_vec = '0;
    sel_idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        sel_vec    = '0;
        sel_vec[i] = 1'b1;
        sel_idx    = IDX_W'(i);
      end
    end
  end

  assign sel_valid = |hit_vec;
  assign offset = sel_valid ? (addr - bases[sel_idx*AW +: AW]) : '0;

  assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec));

  assert_sel_in_hits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_vec & ~hit_vec) == '0);

  assert_sel_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid == (sel_vec != '0));

  assert_hit_needs_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & ~mapped) == '0);
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
  import bar_window_pkg::*;
#(
  parameter int NUM_BARS = 6,
  parameter logic [(NUM_BARS+1)*32-1:0] WIN_SIZE =
    {32'h0001_0000, 32'h0000_0001, 32'h0000_0000, 32'h0000_0010,
     32'h0010_0000, 32'h0000_0100, 32'h0000_1000},
  parameter logic [NUM_BARS-1:0] WIN_IO = 6'b101010,
  localparam int NREG = NUM_BARS + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [15:0]            cmd_reg,
  input  logic [NUM_BARS*32-1:0] bar_regs,
  input  logic [31:0]            rom_reg,
  input  logic [31:0]            req_addr,
  input  logic                   req_is_io,
  output logic [NREG-1:0]        hit_vec,
  output logic [NREG-1:0]        sel_vec,
  output logic                   sel_valid,
  output logic [31:0]            sel_offset,
  output logic [NREG-1:0]        win_mapped,
  output logic [NREG-1:0]        place_chg
);
  localparam logic [NREG-1:0] ALL_IO = {1'b0, WIN_IO};

  logic io_space_en;
  logic mem_space_en;
  logic [NREG*AW-1:0] win_bases;

  assign io_space_en  = cmd_reg[0];
  assign mem_space_en = cmd_reg[1];

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_win
      if (i < NUM_BARS) begin : g_bar
        bar_window_eval #(
          .SIZE(WIN_SIZE[i*AW +: AW]), .IS_IO(WIN_IO[i]), .IS_ROM(1'b0)
        ) u_eval (
          .clk(clk), .rst_n(rst_n),
          .raw(bar_regs[i*AW +: AW]),
          .space_en(WIN_IO[i] ? io_space_en : mem_space_en),
          .mapped_q(win_mapped[i]),
          .base_q(win_bases[i*AW +: AW]),
          .chg_q(place_chg[i])
        );
      end else begin : g_rom
        bar_window_eval #(
          .SIZE(WIN_SIZE[i*AW +: AW]), .IS_IO(1'b0), .IS_ROM(1'b1)
        ) u_eval (
          .clk(clk), .rst_n(rst_n),
          .raw(rom_reg),
          .space_en(mem_space_en),
          .mapped_q(win_mapped[i]),
          .base_q(win_bases[i*AW +: AW]),
          .chg_q(place_chg[i])
        );
      end
    end
  endgenerate

  bar_hit_select #(
    .NREG(NREG), .WIN_SIZE(WIN_SIZE), .WIN_IO(ALL_IO)
  ) u_sel (
    .clk(clk), .rst_n(rst_n),
    .mapped(win_mapped), .bases(win_bases),
    .addr(req_addr), .is_io(req_is_io),
    .hit_vec(hit_vec), .sel_vec(sel_vec),
    .sel_valid(sel_valid), .offset(sel_offset)
  );

  assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (win_mapped == '0));
endmodule

// File: tb/bar_window_decoder_bench.sv
module bar_window_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cmd_reg;
  logic [191:0] bar_regs;
  logic [31:0] rom_reg;
  logic [31:0] req_addr;
  logic        req_is_io;
  logic [6:0]  hit_vec, sel_vec, win_mapped, place_chg;
  logic        sel_valid;
  logic [31:0] sel_offset;

  int checks = 0;
  int errors = 0;

  // Window layout used by the bench:
  // 0 mem 4K, 1 io 256, 2 mem 1M, 3 io 16, 4 size 0, 5 io size 1, 6 ROM 64K
  bar_window_decoder u_bar_window_decoder (
    .clk(clk), .rst_n(rst_n), .cmd_reg(cmd_reg), .bar_regs(bar_regs),
    .rom_reg(rom_reg), .req_addr(req_addr), .req_is_io(req_is_io),
    .hit_vec(hit_vec), .sel_vec(sel_vec), .sel_valid(sel_valid),
    .sel_offset(sel_offset), .win_mapped(win_mapped), .place_chg(place_chg)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic set_bar(input int i, input logic [31:0] v);
    bar_regs[i*32 +: 32] = v;
  endtask

  // One clock edge, then sample away from it.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic probe(input logic [31:0] a, input logic io);
    req_addr = a;
    req_is_io = io;
    #1;
  endtask

  task automatic t_reset();
    chk("R11 mapped after reset", {25'd0, win_mapped}, 32'h0);
    chk("R11 pulse after reset", {25'd0, place_chg}, 32'h0);
    probe(32'h8000_0000, 1'b0);
    chk("R11 hit after reset", {25'd0, hit_vec}, 32'h0);
  endtask

  task automatic t_cmd_gating();
    set_bar(0, 32'h8000_0000); set_bar(1, 32'h0000_C000);
    set_bar(2, 32'h9000_0000); set_bar(3, 32'h0000_FFF0);
    set_bar(4, 32'h0000_1234); set_bar(5, 32'h0000_0040);
    rom_reg = 32'h000F_0001;
    cmd_reg = 16'h0000; step(); step();
    chk("R1 cmd=0", {25'd0, win_mapped}, 32'h00);
    cmd_reg = 16'h0001; step();
    chk("R1 io only", {25'd0, win_mapped}, 32'h0A);
    cmd_reg = 16'h0002; step();
    chk("R1 mem only", {25'd0, win_mapped}, 32'h45);
    cmd_reg = 16'h0003; step();
    chk("R1 both", {25'd0, win_mapped}, 32'h4F);
    step();
  endtask

  task automatic t_rom_enable();
    probe(32'h000F_0010, 1'b0);
    chk("R2 rom hit enabled", {25'd0, hit_vec}, 32'h40);
    chk("R3 rom offset", sel_offset, 32'h10);
    rom_reg = 32'h000F_0000; step();
    chk("R2 rom bit0 clear", {31'd0, win_mapped[6]}, 32'h0);
    probe(32'h000F_0010, 1'b0);
    chk("R2 rom no hit", {25'd0, hit_vec}, 32'h0);
    rom_reg = 32'h000F_0001; step(); step();
  endtask

  task automatic t_decode();
    probe(32'h8000_0000, 1'b0);
    chk("R3 first byte", {25'd0, sel_vec}, 32'h01);
    chk("R3 first offset", sel_offset, 32'h0);
    probe(32'h8000_0FFF, 1'b0);
    chk("R3 last byte", {25'd0, hit_vec}, 32'h01);
    chk("R3 last offset", sel_offset, 32'hFFF);
    probe(32'h8000_1000, 1'b0);
    chk("R3 past end", {31'd0, sel_valid}, 32'h0);
    probe(32'h0000_C0FF, 1'b1);
    chk("R3 io last", {25'd0, hit_vec}, 32'h02);
    chk("R3 io offset", sel_offset, 32'hFF);
    set_bar(0, 32'h8000_0ABC); step();
    chk("R10 low bits no pulse", {25'd0, place_chg}, 32'h0);
    probe(32'h8000_0004, 1'b0);
    chk("R3 masked base offset", sel_offset, 32'h4);
  endtask

  task automatic t_space_type();
    probe(32'h8000_0010, 1'b1);
    chk("R8 io misses mem", {25'd0, hit_vec}, 32'h0);
    probe(32'h0000_C010, 1'b0);
    chk("R8 mem misses io", {25'd0, hit_vec}, 32'h0);
  endtask

  task automatic t_invalid();
    chk("R5 size-1 unmapped", {31'd0, win_mapped[5]}, 32'h0);
    probe(32'h0000_0040, 1'b1);
    chk("R5 size-1 no hit", {25'd0, hit_vec}, 32'h0);
    chk("R7 size-0 unmapped", {31'd0, win_mapped[4]}, 32'h0);
    probe(32'h0000_1234, 1'b0);
    chk("R7 size-0 no hit", {25'd0, hit_vec}, 32'h0);
    probe(32'h0000_FFFF, 1'b1);
    chk("R6 io at limit hit", {25'd0, hit_vec}, 32'h08);
    chk("R6 io at limit offset", sel_offset, 32'hF);
    set_bar(3, 32'h0001_0000); step();
    chk("R6 io past limit", {31'd0, win_mapped[3]}, 32'h0);
    set_bar(0, 32'h0000_0ABC); step();
    chk("R4 zero base", {31'd0, win_mapped[0]}, 32'h0);
    probe(32'h0000_0010, 1'b0);
    chk("R4 zero base no hit", {25'd0, hit_vec}, 32'h0);
    set_bar(0, 32'h8000_0000); set_bar(3, 32'h0000_FFF0); step(); step();
  endtask

  task automatic t_priority();
    set_bar(2, 32'h8000_0000); step(); step();
    probe(32'h8000_0100, 1'b0);
    chk("R9 all hits", {25'd0, hit_vec}, 32'h05);
    chk("R9 lowest picked", {25'd0, sel_vec}, 32'h01);
    chk("R9 offset of pick", sel_offset, 32'h100);
    probe(32'h8000_2000, 1'b0);
    chk("R9 only upper", {25'd0, sel_vec}, 32'h04);
    chk("R9 upper offset", sel_offset, 32'h2000);
    set_bar(2, 32'h9000_0000); step(); step();
  endtask

  task automatic t_pulse();
    set_bar(1, 32'h0000_D000); step();
    chk("R10 move pulse", {25'd0, place_chg}, 32'h02);
    step();
    chk("R10 pulse one cycle", {25'd0, place_chg}, 32'h0);
    probe(32'h0000_D001, 1'b1);
    chk("R10 new placement hit", {25'd0, hit_vec}, 32'h02);
    cmd_reg = 16'h0001; step();
    chk("R10 unmap pulses", {25'd0, place_chg}, 32'h45);
    step();
    chk("R10 steady no pulse", {25'd0, place_chg}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    cmd_reg = '0; bar_regs = '0; rom_reg = '0;
    req_addr = '0; req_is_io = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cmd_gating();
    t_rom_enable();
    t_decode();
    t_space_type();
    t_invalid();
    t_priority();
    t_pulse();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule